// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns bytes written by a host into asynchronous serial frames on a single transmit line. A line-control byte sets the format of each character: the data width (5 to 8 bits), the parity scheme (none, even, odd, or a parity bit forced to 0 or 1), and whether characters wait in a multi-entry FIFO or in a single holding register. The format is captured when a character starts, so reprogramming the line-control byte never corrupts a character already on the line.

A free-running baud tick enable comes from an external rate generator. Each serial bit lasts a fixed number of ticks. A UART enable input controls whether new characters may leave the buffer. Full and empty flags report the buffer state, and a busy flag reports that a frame is being shifted out.

Top module: `uart_frame_tx`

## Requirements
- R1: Line-control bits 6:5 set the data bits per frame: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data leaves least significant bit first, and the upper bits of the written byte beyond the width are not sent.
- R2: A frame is a start bit (0), then the data bits, then the optional parity bit, then a stop bit (1). Each bit lasts 16 baud ticks, and the line rests at 1 between frames.
- R3: With line-control bit 1 (parity enable) at 0, no parity bit is sent, whatever bits 2 and 7 hold.
- R4: With bit 1 = 1, bit 2 = 1 and bit 7 = 0, the parity bit makes the count of ones over the data and parity bits even.
- R5: With bit 1 = 1, bit 2 = 0 and bit 7 = 0, the parity bit makes that count odd.
- R6: With bits 1 and 7 both 1, the parity bit is a constant: 1 when bit 2 is 0, and 0 when bit 2 is 1.
- R7: With line-control bit 4 = 1, up to 16 characters are buffered. full_o is high while 16 are held, and a write made while full is dropped.
- R8: With bit 4 = 0, buffering is a single holding register. full_o rises after one character, and a second write is dropped.
- R9: The format is sampled when a character starts. A line-control change while a frame is in flight does not affect that frame, but it applies to the characters that start after it.
- R10: While en_i is 0, no new character starts: tx_o stays 1 and busy_o stays 0 with characters waiting.
- R11: After reset, tx_o = 1, busy_o = 0, empty_o = 1 and full_o = 0. empty_o is high exactly when no character is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | UART enable; gates the start of new characters |
| baud_tick_i | input | 1 | Baud tick enable, 16 per serial bit |
| wr_valid_i | input | 1 | Write strobe for one character |
| wr_data_i | input | 8 | Character to send |
| lcr_i | input | 8 | Line-control byte: bit 1 parity enable, bit 2 even select, bit 4 FIFO enable, bits 6:5 width, bit 7 stick parity |
| tx_o | output | 1 | Serial transmit line |
| busy_o | output | 1 | Frame in progress |
| full_o | output | 1 | Buffer full |
| empty_o | output | 1 | No character waiting |

## Verification
The hardest case to reach is a line-control change in the middle of a frame. The stimulus must make the old format apply to the character on the line and the new format apply to the next one, which means the next character has to wait in the buffer across the change. The bench writes one character, waits until busy_o rises, then changes the width and the parity scheme and writes a second character. The scoreboard expects each character with the format it was queued under. To fill the buffer and test the dropped writes, the bench holds en_i low while it writes past capacity, so that nothing drains.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic       stick;
    logic [1:0] wlen;
    logic       fifo_en;
    logic       even;
    logic       par_en;
  } lcr_t;

  function automatic lcr_t decode_lcr(input logic [7:0] b);
    lcr_t l;
    l.stick   = b[7];
    l.wlen    = b[6:5];
    l.fifo_en = b[4];
    l.even    = b[2];
    l.par_en  = b[1];
    return l;
  endfunction

  // parity over the active data bits; sticky modes override
  function automatic logic calc_parity(input logic [7:0] d, input lcr_t l);
    logic [7:0] mask;
    logic       x;
    mask = 8'hFF >> (3 - l.wlen);
    x    = ^(d & mask);
    if (l.stick) return ~l.even;
    return l.even ? x : ~x;
  endfunction

endpackage

// File: rtl/uart_tx_buf.sv
module uart_tx_buf #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_en_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q, cap;
  logic          do_push, do_pop;

  assign cap     = fifo_en_i ? CW'(DEPTH) : CW'(1);
  assign full_o  = count_q >= cap;
  assign empty_o = count_q == '0;
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign pop_data_o = mem_q[rptr_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= push_data_i;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH)); // R7
  AST_DROP_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i |=> count_q == $past(count_q)); // R8

endmodule

// File: rtl/uart_tx_ser.sv
module uart_tx_ser
  import uart_tx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          baud_tick_i,
  input  logic [7:0]    lcr_i,
  input  logic          empty_i,
  input  logic [DW-1:0] data_i,
  output logic          pop_o,
  output logic          tx_o,
  output logic          busy_o
);
  localparam int TW = $clog2(OVS);

  tx_state_e     state_q;
  logic [TW-1:0] tick_q;
  logic [2:0]    bit_q, last_q;
  logic [7:0]    sh_q;
  logic          par_en_q, par_val_q;
  logic          bit_done;
  lcr_t          lcr;

  assign lcr      = decode_lcr(lcr_i);
  assign pop_o    = en_i && (state_q == ST_IDLE) && !empty_i;
  assign bit_done = baud_tick_i && (tick_q == TW'(OVS - 1));
  assign busy_o   = state_q != ST_IDLE;

  always_comb begin
    case (state_q)
      ST_START: tx_o = 1'b0;
      ST_DATA:  tx_o = sh_q[0];
      ST_PAR:   tx_o = par_val_q;
      default:  tx_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      tick_q    <= '0;
      bit_q     <= '0;
      last_q    <= '0;
      sh_q      <= '0;
      par_en_q  <= 1'b0;
      par_val_q <= 1'b0;
    end else begin
      if (state_q != ST_IDLE && baud_tick_i) tick_q <= tick_q + 1'b1;
      case (state_q)
        ST_IDLE: if (pop_o) begin
          // format captured here and held for the whole frame
          sh_q      <= 8'(data_i);
          last_q    <= 3'(lcr.wlen) + 3'd4;
          par_en_q  <= lcr.par_en;
          par_val_q <= calc_parity(8'(data_i), lcr);
          tick_q    <= '0;
          state_q   <= ST_START;
        end
        ST_START: if (bit_done) begin
          bit_q   <= '0;
          state_q <= ST_DATA;
        end
        ST_DATA: if (bit_done) begin
          sh_q <= sh_q >> 1;
          if (bit_q == last_q) state_q <= par_en_q ? ST_PAR : ST_STOP;
          else                 bit_q   <= bit_q + 1'b1;
        end
        ST_PAR:  if (bit_done) state_q <= ST_STOP;
        ST_STOP: if (bit_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !baud_tick_i |=> $stable(state_q) && $stable(tick_q)); // R2
  AST_FMT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != ST_IDLE && $past(state_q) != ST_IDLE |-> $stable(par_val_q) && $stable(last_q) && $stable(par_en_q)); // R9
  AST_NO_START_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE && !en_i |=> state_q == ST_IDLE); // R10

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OVS   = 16,
  parameter int DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          baud_tick_i,
  input  logic          wr_valid_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [7:0]    lcr_i,
  output logic          tx_o,
  output logic          busy_o,
  output logic          full_o,
  output logic          empty_o
);
  logic          pop;
  logic [DW-1:0] head;
  lcr_t          lcr;

  assign lcr = decode_lcr(lcr_i);

  uart_tx_buf #(.DEPTH(DEPTH), .DW(DW)) i_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fifo_en_i   (lcr.fifo_en),
    .push_i      (wr_valid_i),
    .push_data_i (wr_data_i),
    .pop_i       (pop),
    .pop_data_o  (head),
    .full_o      (full_o),
    .empty_o     (empty_o)
  );

  uart_tx_ser #(.OVS(OVS), .DW(DW)) i_ser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .baud_tick_i (baud_tick_i),
    .lcr_i       (lcr_i),
    .empty_i     (empty_o),
    .data_i      (head),
    .pop_o       (pop),
    .tx_o        (tx_o),
    .busy_o      (busy_o)
  );

  AST_POP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |-> !empty_o); // R11

endmodule

// File: tb/test_uart_frame_tx.sv
module test_uart_frame_tx;
  localparam int BITC = 32; // 16 ticks, one tick every 2 clocks

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, tick = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0, lcr = '0;
  logic tx, busy, full, empty;
  int errors = 0, checks = 0;
  logic [15:0] exp_q [$];

  always #5 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  uart_frame_tx i_uart_frame_tx (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .baud_tick_i(tick),
    .wr_valid_i(wr), .wr_data_i(wdata), .lcr_i(lcr),
    .tx_o(tx), .busy_o(busy), .full_o(full), .empty_o(empty));

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  function automatic int frame_len(input logic [7:0] l);
    return 1 + (int'(l[6:5]) + 5) + (l[1] ? 1 : 0) + 1;
  endfunction

  // bit i of result = line level during frame bit i
  function automatic logic [11:0] frame_bits(input logic [7:0] d, input logic [7:0] l);
    logic [11:0] f = '0;
    int n = int'(l[6:5]) + 5;
    int ones = 0;
    logic p;
    for (int i = 0; i < n; i++) begin
      f[1+i] = d[i];
      ones += d[i];
    end
    if (l[7]) p = ~l[2];
    else if (l[2]) p = ones[0];
    else p = ~ones[0];
    if (l[1]) begin
      f[1+n] = p;
      f[2+n] = 1'b1;
    end else f[1+n] = 1'b1;
    return f;
  endfunction

  task automatic send(input logic [7:0] d, input bit accept);
    @(negedge clk);
    wr = 1'b1; wdata = d;
    if (accept) exp_q.push_back({d, lcr});
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (!(empty && !busy)) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  // monitor: sample each bit near its centre
  initial begin
    forever begin
      logic [15:0] e;
      logic [11:0] exp_b, got;
      int len;
      @(negedge clk);
      if (rst_n && tx == 1'b0) begin
        got = '0;
        repeat (BITC/2 - 1) @(negedge clk);
        got[0] = tx;
        if (exp_q.size() == 0) begin
          errors++; checks++;
          $display("FAIL R7 unexpected frame actual=1 expected=0");
          len = 12;
        end else begin
          e = exp_q.pop_front();
          len = frame_len(e[7:0]);
        end
        for (int i = 1; i < len; i++) begin
          repeat (BITC) @(negedge clk);
          got[i] = tx;
        end
        if (e !== 'x) begin
          exp_b = frame_bits(e[15:8], e[7:0]);
          chk($sformatf("R1 R2 R3 R4 R5 R6 frame lcr=%0h d=%0h", e[7:0], e[15:8]),
              int'(got), int'(exp_b & ((12'h1 << len) - 1)));
        end
        e = 'x;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset tx", tx, 1); chk("R11 reset busy", busy, 0);
    chk("R11 reset empty", empty, 1); chk("R11 reset full", full, 0);
    rst_n = 1'b1;

    // R7 fill FIFO with transmission held off
    lcr = 8'b0111_0000;
    for (int i = 0; i < 16; i++) send(8'(8'h30 + i), 1'b1);
    @(negedge clk);
    chk("R7 full after 16", full, 1);
    chk("R11 not empty", empty, 0);
    send(8'hEE, 1'b0);
    repeat (50) @(negedge clk);
    chk("R10 idle while disabled tx", tx, 1);
    chk("R10 idle while disabled busy", busy, 0);
    en = 1'b1;
    drain();
    chk("R11 empty after drain", empty, 1);
    chk("R7 all frames seen", exp_q.size(), 0);

    // R1 R3 R4 R5 R6 every width against every parity scheme
    for (int w = 0; w < 4; w++) begin
      for (int m = 0; m < 5; m++) begin
        logic [7:0] pbits;
        case (m)
          0: pbits = 8'b1000_0100; // R3 parity off, other bits ignored
          1: pbits = 8'b0000_0110; // R4 even
          2: pbits = 8'b0000_0010; // R5 odd
          3: pbits = 8'b1000_0010; // R6 forced 1
          default: pbits = 8'b1000_0110; // R6 forced 0
        endcase
        lcr = pbits | 8'h10 | (8'(w) << 5);
        send(8'(8'hA5 ^ (w * 37) ^ (m * 11)), 1'b1);
        drain();
      end
    end
    chk("R6 all parity frames seen", exp_q.size(), 0);

    // R8 holding register
    en = 1'b0;
    lcr = 8'b0110_0010;
    send(8'h5A, 1'b1);
    @(negedge clk);
    chk("R8 full after one", full, 1);
    send(8'hC3, 1'b0);
    en = 1'b1;
    drain();
    chk("R8 second write dropped", exp_q.size(), 0);

    // R9 format change while a frame is on the line
    lcr = 8'b0111_0000;
    send(8'hF1, 1'b1);
    @(negedge clk);
    while (!busy) @(negedge clk);
    repeat (70) @(negedge clk);
    lcr = 8'b1001_0110;
    send(8'h2C, 1'b1);
    drain();
    chk("R9 both frames seen", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule